// File: doc/BRIEF.md
# Issue-Advanced Multiplier Pipeline

This block is a three-stage multiply pipeline with its own 32-entry, 32-bit register file. The pipeline does not move on clock edges alone. It moves one step each time a pipelined multiply is issued, and it holds its contents through cycles with no issue. Every issue names two source registers and one destination. The destination does not receive the product of the current operands. It receives the product leaving the last stage on that issue, which comes from the multiply issued three pipelined issues earlier. Software therefore fills the pipe with throw-away destinations and drains it with dummy issues. Multiplication is 32-bit integer, truncated to the low 32 bits.

A scalar mode issues a non-pipelined multiply. Its product goes straight to the destination, and the pipeline does not advance. A load port fills registers from the memory side. A read port returns one register, and a second output returns the even/odd pair that contains it as one 64-bit value. Registers 0 and 1 are reserved and always read zero. Naming register 0 or 1 as a destination discards the result.

Top module: `mpipe_unit`

## Requirements
- R1: A synchronous reset clears every register to zero and marks all three pipeline stages empty.
- R2: The pipeline advances only on a pipelined issue (`iss_vld`=1, `iss_scalar`=0). Idle cycles and scalar issues leave its contents unchanged, however many there are.
- R3: On a pipelined issue, the destination receives the low 32 bits of the product whose operands were captured by the third-previous pipelined issue.
- R4: An empty stage that reaches the output delivers zero. That zero is still written to the named destination.
- R5: Registers 0 and 1 always read zero. Writes to either, whether from a multiply or from the load port, are discarded.
- R6: Source operands are read at issue, so a later write to a source register does not change a product already in flight.
- R7: A register write takes effect on the issuing (or loading) clock edge and is visible on `rd_data` in the next cycle.
- R8: A scalar issue writes the truncated product of its sources to its destination on the same edge.
- R9: `rd_pair` returns {register odd, register even} for the pair selected by `rd_idx` with bit 0 ignored.
- R10: When a multiply write and a load target the same register on the same edge, the multiply result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | Issue a multiply this cycle |
| iss_scalar | input | 1 | With iss_vld: non-pipelined scalar multiply |
| src_a | input | 5 | First source register index |
| src_b | input | 5 | Second source register index |
| dst | input | 5 | Destination register index |
| ld_vld | input | 1 | Load a register this cycle |
| ld_idx | input | 5 | Load target index |
| ld_data | input | 32 | Load value |
| rd_idx | input | 5 | Read port index |
| rd_data | output | 32 | Register value at rd_idx |
| rd_pair | output | 64 | Even/odd pair containing rd_idx, odd register in the upper half |

## Verification
The bench targets the points where an off-by-one pipe would differ from the intended one. It checks that the destination of the fourth issue after reset gets the first product. A design that advanced on every clock would deliver stale or zero products after idle gaps. A design that multiplied at writeback would see source registers that were rewritten in the meantime. The bench also checks that a scalar issue between pipelined issues does not shift the queue, that an empty stage still overwrites its destination with zero, and that a load colliding with a multiply write loses. A long random stream is then checked register by register against a queue model on every cycle.

// File: rtl/mpipe_pkg.sv
package mpipe_pkg;

    parameter int DATA_W = 32;
    parameter int REG_N  = 32;
    parameter int RSV_N  = 2;
    localparam int IDX_W = $clog2(REG_N);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    // operands held by the entry stage
    typedef struct packed {
        logic  vld;
        word_t a;
        word_t b;
    } opnd_t;

    // product carried by the later stages
    typedef struct packed {
        logic  vld;
        word_t p;
    } prod_t;

    // one register-file write request
    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t data;
    } wr_t;

    function automatic word_t mul_trunc(input word_t a, input word_t b);
        return a * b;
    endfunction

    function automatic logic writable(input ridx_t idx);
        return int'(idx) >= RSV_N;
    endfunction

endpackage

// File: rtl/mpipe_regfile.sv
module mpipe_regfile
    import mpipe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wr_t   wr_mul,
    input  wr_t   wr_ld,
    input  ridx_t ra_idx,
    input  ridx_t rb_idx,
    input  ridx_t rc_idx,
    output word_t ra_data,
    output word_t rb_data,
    output word_t rc_data,
    output logic [2*DATA_W-1:0] rc_pair
);

    word_t mem [REG_N];
    ridx_t pair_lo;
    ridx_t pair_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_N; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < REG_N; i++) begin
                if (i >= RSV_N) begin
                    // multiply writeback has priority over load
                    if (wr_mul.en && int'(wr_mul.idx) == i)
                        mem[i] <= wr_mul.data;
                    else if (wr_ld.en && int'(wr_ld.idx) == i)
                        mem[i] <= wr_ld.data;
                end
            end
        end
    end

    assign pair_lo = {rc_idx[IDX_W-1:1], 1'b0};
    assign pair_hi = {rc_idx[IDX_W-1:1], 1'b1};

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];
    assign rc_data = mem[rc_idx];
    assign rc_pair = {mem[pair_hi], mem[pair_lo]};

endmodule

// File: rtl/mpipe_stages.sv
module mpipe_stages
    import mpipe_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  opnd_t in_op,
    output prod_t out_p
);

    opnd_t s_op;
    prod_t s_res [1:DEPTH-1];

    // entry stage: capture operands at issue
    always_ff @(posedge clk) begin
        if (rst)      s_op <= '0;
        else if (adv) s_op <= in_op;
    end

    // first product stage
    always_ff @(posedge clk) begin
        if (rst) begin
            s_res[1] <= '0;
        end else if (adv) begin
            s_res[1].vld <= s_op.vld;
            s_res[1].p   <= s_op.vld ? mul_trunc(s_op.a, s_op.b) : '0;
        end
    end

    // remaining stages shift the product
    for (genvar k = 2; k < DEPTH; k++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst)      s_res[k] <= '0;
            else if (adv) s_res[k] <= s_res[k-1];
        end
    end

    assign out_p = s_res[DEPTH-1];

endmodule

// File: rtl/mpipe_unit.sv
module mpipe_unit
    import mpipe_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_vld,
    input  logic                 iss_scalar,
    input  logic [IDX_W-1:0]     src_a,
    input  logic [IDX_W-1:0]     src_b,
    input  logic [IDX_W-1:0]     dst,
    input  logic                 ld_vld,
    input  logic [IDX_W-1:0]     ld_idx,
    input  logic [DATA_W-1:0]    ld_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic [2*DATA_W-1:0]  rd_pair
);

    word_t opa;
    word_t opb;
    logic  adv;
    opnd_t pipe_in;
    prod_t tail;
    logic  tail_vld;
    word_t tail_prod;
    wr_t   wr_mul;
    wr_t   wr_ld;

    assign adv = iss_vld & ~iss_scalar;

    assign pipe_in.vld = 1'b1;
    assign pipe_in.a   = opa;
    assign pipe_in.b   = opb;

    mpipe_stages #(.DEPTH(DEPTH)) stages_i (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .in_op (pipe_in),
        .out_p (tail)
    );

    assign tail_vld  = tail.vld;
    assign tail_prod = tail.p;

    assign wr_mul.en   = iss_vld & writable(dst);
    assign wr_mul.idx  = dst;
    assign wr_mul.data = iss_scalar ? mul_trunc(opa, opb) : tail_prod;

    assign wr_ld.en   = ld_vld & writable(ld_idx);
    assign wr_ld.idx  = ld_idx;
    assign wr_ld.data = ld_data;

    mpipe_regfile rf_i (
        .clk     (clk),
        .rst     (rst),
        .wr_mul  (wr_mul),
        .wr_ld   (wr_ld),
        .ra_idx  (src_a),
        .rb_idx  (src_b),
        .rc_idx  (rd_idx),
        .ra_data (opa),
        .rb_data (opb),
        .rc_data (rd_data),
        .rc_pair (rd_pair)
    );

endmodule

// File: rtl/mpipe_unit_chk.sv
module mpipe_unit_chk
    import mpipe_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        iss_vld,
    input logic        iss_scalar,
    input ridx_t       dst,
    input ridx_t       rd_idx,
    input word_t       rd_data,
    input logic        tail_vld,
    input word_t       tail_prod,
    input word_t       opa,
    input word_t       opb
);

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!iss_vld || iss_scalar) |=> ($stable(tail_vld) && $stable(tail_prod))); // R2

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        !tail_vld |-> (tail_prod == '0)); // R4

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_idx) < RSV_N) |-> (rd_data == '0)); // R5

    AST_PIPE_WB: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && !iss_scalar && int'(dst) >= RSV_N)
        |=> ((rd_idx != $past(dst)) || (rd_data == $past(tail_prod)))); // R3

    AST_SCALAR_WB: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && iss_scalar && int'(dst) >= RSV_N)
        |=> ((rd_idx != $past(dst)) || (rd_data == $past(mul_trunc(opa, opb))))); // R8

endmodule

bind mpipe_unit mpipe_unit_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .iss_vld    (iss_vld),
    .iss_scalar (iss_scalar),
    .dst        (dst),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .tail_vld   (tail_vld),
    .tail_prod  (tail_prod),
    .opa        (opa),
    .opb        (opb)
);

// File: tb/mpipe_unit_tb_top.sv
`timescale 1ns/1ps
module mpipe_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        iss_vld, iss_scalar;
    logic [4:0]  src_a, src_b, dst, ld_idx, rd_idx;
    logic        ld_vld;
    logic [31:0] ld_data, rd_data;
    logic [63:0] rd_pair;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [31:0] m_rf [32];
    logic [32:0] m_q  [$];

    always #5 clk = ~clk;

    mpipe_unit dut_i (
        .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_scalar(iss_scalar),
        .src_a(src_a), .src_b(src_b), .dst(dst),
        .ld_vld(ld_vld), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_pair(rd_pair)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        rd_idx = 5'(idx);
        #0.1;
        v = rd_data;
    endtask

    // compare every register and every pair against the model
    task automatic compare_all(input string tag);
        logic [31:0] v;
        int bad_i = -1, bad_p = -1;
        logic [31:0] got_r = '0;
        logic [63:0] got_p = '0;
        for (int i = 0; i < 32; i++) begin
            rd(i, v);
            if (v !== m_rf[i] && bad_i < 0) begin bad_i = i; got_r = v; end
            if (rd_pair !== {m_rf[i | 1], m_rf[i & 30]} && bad_p < 0) begin
                bad_p = i; got_p = rd_pair;
            end
        end
        if (bad_i >= 0) chk(tag, {32'd0, got_r}, {32'd0, m_rf[bad_i]});
        else            chk(tag, 64'd0, 64'd0);
        if (bad_p >= 0) chk("R9", got_p, {m_rf[bad_p | 1], m_rf[bad_p & 30]});
        else            chk("R9", 64'd0, 64'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1; iss_vld = 0; iss_scalar = 0; ld_vld = 0;
        src_a = 0; src_b = 0; dst = 0; ld_idx = 0; ld_data = 0; rd_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_q.delete();
        repeat (3) m_q.push_back(33'd0);
    endtask

    // one cycle of stimulus, model update at the edge, full compare after
    task automatic step(input logic iv, input logic sc, input int a, input int b,
                        input int d, input logic lv, input int li, input logic [31:0] ldv,
                        input string tag);
        logic [31:0] oa, ob, wv;
        logic [32:0] fr;
        logic wen;
        iss_vld = iv; iss_scalar = sc; src_a = 5'(a); src_b = 5'(b); dst = 5'(d);
        ld_vld = lv; ld_idx = 5'(li); ld_data = ldv;
        oa = m_rf[a]; ob = m_rf[b]; wen = 1'b0; wv = '0;
        if (iv) begin
            wen = 1'b1;
            if (sc) begin
                wv = oa * ob;
            end else begin
                fr = m_q.pop_front();
                m_q.push_back({1'b1, 32'(oa * ob)});
                wv = fr[31:0];
            end
        end
        @(posedge clk);
        if (lv && li > 1) m_rf[li] = ldv;
        if (wen && d > 1) m_rf[d] = wv;
        @(negedge clk);
        iss_vld = 0; ld_vld = 0;
        compare_all(tag);
    endtask

    task automatic P(input int a, input int b, input int d);
        step(1'b1, 1'b0, a, b, d, 1'b0, 0, 32'd0, "R3");
    endtask
    task automatic S(input int a, input int b, input int d);
        step(1'b1, 1'b1, a, b, d, 1'b0, 0, 32'd0, "R8");
    endtask
    task automatic L(input int i, input logic [31:0] v);
        step(1'b0, 1'b0, 0, 0, 0, 1'b1, i, v, "R7");
    endtask
    task automatic IDLE(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 0, 0, 0, 1'b0, 0, 32'd0, "R2");
    endtask

    task automatic load_base();
        L(2, 3); L(3, 5); L(4, 7); L(5, 11); L(6, 32'h0001_0000); L(7, 32'h0001_0001);
    endtask

    initial begin
        logic [31:0] v;
        logic bad;
        do_reset();
        // R1: all registers zero after reset
        bad = 1'b0;
        for (int i = 0; i < 32; i++) begin rd(i, v); if (v !== 0) bad = 1'b1; end
        chk("R1", {63'd0, bad}, 64'd0);

        // R4: empty stage writes zero into named destination
        L(20, 32'hDEAD_BEEF);
        rd(20, v); chk("R7", {32'd0, v}, {32'd0, 32'hDEAD_BEEF});
        L(2, 3); L(3, 5);
        P(2, 3, 20);
        rd(20, v); chk("R4", {32'd0, v}, 64'd0);

        // R3: basic fill and drain
        do_reset(); load_base();
        P(2, 3, 0); P(4, 5, 0); P(6, 7, 0);
        P(0, 0, 10); P(0, 0, 11); P(0, 0, 12);
        rd(10, v); chk("R3", {32'd0, v}, 64'd15);
        rd(11, v); chk("R3", {32'd0, v}, 64'd77);
        rd(12, v); chk("R3", {32'd0, v}, 64'h0001_0000);

        // R2 and R8: idle gaps and a scalar issue do not advance
        do_reset(); load_base();
        P(2, 3, 0); IDLE(5); P(4, 5, 0); IDLE(3); P(2, 2, 0); IDLE(4);
        P(0, 0, 13);
        rd(13, v); chk("R2", {32'd0, v}, 64'd15);
        S(4, 5, 14);
        rd(14, v); chk("R8", {32'd0, v}, 64'd77);
        P(0, 0, 15);
        rd(15, v); chk("R8", {32'd0, v}, 64'd77);
        // R5: destination 1 and 0 discard, loads to them discarded
        P(0, 0, 1);
        rd(1, v); chk("R5", {32'd0, v}, 64'd0);
        step(1'b0, 1'b0, 0, 0, 0, 1'b1, 0, 32'h1234_5678, "R5");
        rd(0, v); chk("R5", {32'd0, v}, 64'd0);
        step(1'b0, 1'b0, 0, 0, 0, 1'b1, 1, 32'h1234_5678, "R5");
        rd(1, v); chk("R5", {32'd0, v}, 64'd0);

        // R6: sources rewritten right after issue
        do_reset(); load_base();
        P(2, 3, 0);
        step(1'b1, 1'b0, 4, 5, 0, 1'b1, 2, 32'd100, "R6");
        L(3, 32'd100);
        P(0, 0, 0); P(0, 0, 17);
        rd(17, v); chk("R6", {32'd0, v}, 64'd15);

        // R10: multiply write beats a load to the same register
        step(1'b1, 1'b1, 4, 5, 18, 1'b1, 18, 32'h0000_AAAA, "R10");
        rd(18, v); chk("R10", {32'd0, v}, 64'd77);

        // R9: pair view
        L(8, 32'h1111_1111); L(9, 32'h2222_2222);
        rd(9, v); chk("R9", rd_pair, 64'h2222_2222_1111_1111);
        rd(8, v); chk("R9", rd_pair, 64'h2222_2222_1111_1111);

        // R3 truncation with large operands
        L(21, 32'hFFFF_FFFF); L(22, 32'hFFFF_FFFF);
        S(21, 22, 23);
        rd(23, v); chk("R3", {32'd0, v}, 64'd1);

        // random stream compared every cycle
        for (int k = 0; k < 400; k++) begin
            int r = int'($urandom_range(0, 9));
            if (r < 5)      P(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                              int'($urandom_range(0, 31)));
            else if (r < 6) S(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                              int'($urandom_range(0, 31)));
            else if (r < 8) L(int'($urandom_range(0, 31)), $urandom);
            else            IDLE(1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule